// File: doc/BRIEF.md
# Cache-Line Address Monitor Wakeup Unit

This unit watches one physical address window, one cache line wide, for a core that has been put to sleep. The core arms the window by giving a base address and a tag that names the instruction family doing the arming: privileged, extended or user. A snooped write port reports each store seen on the fabric as a start address and a byte length. When a store overlaps the window while it is armed, the unit drops the armed state, wakes the core and sends a one-cycle pulse that cancels any running timed-wait timer. An explicit clear input also drops the armed state.

The activity state machine has three named states: `ACT_RUN` (core active), `ACT_WAIT` (plain wait) and `ACT_WAIT_IRQ` (wait that an interrupt-break event may end). Its transitions are: `ACT_RUN -> ACT_WAIT` on an accepted wait request without the interrupt hint; `ACT_RUN -> ACT_WAIT_IRQ` on an accepted wait request with the hint; `ACT_WAIT -> ACT_RUN` on a monitor hit or an unmasked interrupt; `ACT_WAIT_IRQ -> ACT_RUN` on a monitor hit, an unmasked interrupt or an interrupt-break event. A wait request from a family is accepted only when the window was armed by that same family. A monitorless wait skips the armed test and clears the window. The overlap test treats the last byte of the line as outside the window: a write that starts exactly at base plus line size minus one does not wake the core.

Top module: `mon_wake_unit`

## Requirements
- R1: After reset `armed` is 0, `armed_src` is 0, `act_state` is 0 (`ACT_RUN`) and `timer_cancel` is 0.
- R2: An arm request with `arm_src` 1 (privileged), 2 (extended) or 3 (user) stores the address and tag, visible on `armed`/`armed_src` after the next clock edge. It replaces any earlier address and tag. It wins over a clear or a hit in the same cycle. An arm request with `arm_src` 0 is ignored.
- R3: A snooped write hits only when the unit is armed, start < base + LINE_BYTES - 1, and start + length > base. Both sums are formed one bit wider than the address, so they do not wrap.
- R4: A hit clears `armed` and sets `armed_src` to 0 after the next edge.
- R5: A hit while `act_state` is 1 (`ACT_WAIT`) or 2 (`ACT_WAIT_IRQ`) returns it to 0 after the next edge.
- R6: A hit raises `timer_cancel` for exactly the one cycle after the hit. With no snooped write, `timer_cancel` is low in the next cycle.
- R7: While not armed, snooped writes are ignored: no state change and no `timer_cancel` pulse.
- R8: `mon_clear` clears `armed` and `armed_src` after the next edge.
- R9: In `ACT_RUN`, a non-monitorless wait request with `wait_family` 0 sleeps only if `armed_src` is 1, and one with `wait_family` 1 only if `armed_src` is 2. Otherwise it is a no-op and the state stays 0. A hit or an unmasked interrupt in the same cycle also turns any wait request into a no-op.
- R10: In `ACT_RUN`, a monitorless wait request (`wait_monless`=1) clears `armed`/`armed_src` and sleeps whatever the armed state and tag.
- R11: An accepted wait with `wait_hint_irq`=1 enters state 2; with `wait_hint_irq`=0 it enters state 1.
- R12: `irq_unmasked` returns state 1 or 2 to 0. `irq_break` returns only state 2 to 0 and has no effect in state 1.
- R13: Wait requests in state 1 or 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_valid | input | 1 | Arm request strobe |
| arm_addr | input | ADDR_W | Physical base address to monitor |
| arm_src | input | 2 | Arming family tag: 1 privileged, 2 extended, 3 user, 0 ignored |
| snoop_valid | input | 1 | Snooped write strobe |
| snoop_addr | input | ADDR_W | Snooped write start address |
| snoop_len | input | LEN_W | Snooped write length in bytes |
| mon_clear | input | 1 | Explicit monitor clear |
| wait_valid | input | 1 | Wait request strobe |
| wait_family | input | 1 | Requesting family: 0 privileged, 1 extended |
| wait_monless | input | 1 | Monitorless wait: skip armed test and clear monitor |
| wait_hint_irq | input | 1 | Hint bit 0: allow interrupt-break wake |
| irq_unmasked | input | 1 | Unmasked interrupt, wakes either wait state |
| irq_break | input | 1 | Interrupt-break event, wakes only the hinted wait state |
| armed | output | 1 | Monitor armed flag |
| armed_src | output | 2 | Tag of the family that armed the monitor, 0 when idle |
| act_state | output | 2 | Activity state: 0 run, 1 wait, 2 wait with interrupt break |
| timer_cancel | output | 1 | One-cycle pulse cancelling a pending timed-wait timer |

## Verification
The overlap test is driven with writes that end exactly at the base, start exactly on the exclusive last byte, sit one byte inside either edge, straddle the base from below, cover the whole line, and overlap a window near the top of the address space. Together these separate a correct exclusive-end comparison from an inclusive one, from one with swapped bounds and from one that wraps. The wait path is tried with every pairing of family and arming tag, with and without the hint bit, with monitorless requests, and with a hit arriving in the same cycle as a wait. This tells a per-family tag check apart from a plain armed check. The wake paths apply each interrupt kind to each wait state to show that `irq_break` is selective.

// File: rtl/mwu_pkg.sv
package mwu_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PRIV = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_USER = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ACT_RUN      = 2'd0,
        ACT_WAIT     = 2'd1,
        ACT_WAIT_IRQ = 2'd2
    } act_e;

    localparam int unsigned FAMILY_COUNT = 2;

    // Tag a wait family must find in the monitor to be allowed to sleep.
    function automatic src_e family_tag(input logic fam);
        return fam ? SRC_EXT : SRC_PRIV;
    endfunction

endpackage

// File: rtl/mwu_arm_reg.sv
module mwu_arm_reg #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [ADDR_W-1:0]   load_addr,
    input  mwu_pkg::src_e       load_src,
    input  logic                drop,
    output logic                armed_q,
    output logic [ADDR_W-1:0]   base_q,
    output mwu_pkg::src_e       src_q
);
    import mwu_pkg::*;

    // A load always wins over a drop in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            base_q  <= '0;
            src_q   <= SRC_NONE;
        end else if (load) begin
            armed_q <= 1'b1;
            base_q  <= load_addr;
            src_q   <= load_src;
        end else if (drop) begin
            armed_q <= 1'b0;
            src_q   <= SRC_NONE;
        end
    end

endmodule

// File: rtl/mwu_line_match.sv
module mwu_line_match #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LEN_W      = 8,
    parameter int unsigned LINE_BYTES = 64
) (
    input  logic              armed,
    input  logic [ADDR_W-1:0] base,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LEN_W-1:0]  wr_len,
    output logic              hit
);
    localparam int unsigned EXT_W = ADDR_W + 1;
    localparam logic [EXT_W-1:0] LINE_LAST = EXT_W'(LINE_BYTES - 1);

    logic [EXT_W-1:0] win_lo;
    logic [EXT_W-1:0] win_end;
    logic [EXT_W-1:0] wr_lo;
    logic [EXT_W-1:0] wr_end;
    logic             past_end;
    logic             before_base;

    always_comb begin
        win_lo      = {1'b0, base};
        win_end     = win_lo + LINE_LAST;
        wr_lo       = {1'b0, wr_addr};
        wr_end      = wr_lo + EXT_W'(wr_len);
        past_end    = (wr_lo >= win_end);
        before_base = (wr_end <= win_lo);
        hit         = armed && wr_valid && !past_end && !before_base;
    end

endmodule

// File: rtl/mwu_wait_gate.sv
module mwu_wait_gate (
    input  logic          wait_valid,
    input  logic          wait_family,
    input  logic          wait_monless,
    input  logic          armed,
    input  mwu_pkg::src_e src,
    output logic          go,
    output logic          monless_req
);
    import mwu_pkg::*;

    logic [FAMILY_COUNT-1:0] fam_ok;

    // One tag comparator per wait family.
    for (genvar f = 0; f < FAMILY_COUNT; f++) begin : g_fam
        assign fam_ok[f] = armed && (src == family_tag(1'(f)));
    end

    always_comb begin
        monless_req = wait_valid && wait_monless;
        go          = wait_valid && (wait_monless || fam_ok[wait_family]);
    end

endmodule

// File: rtl/mwu_act_fsm.sv
module mwu_act_fsm (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hit,
    input  logic           irq_unmasked,
    input  logic           irq_break,
    input  logic           wait_go,
    input  logic           wait_hint,
    output mwu_pkg::act_e  state_o,
    output logic           running,
    output logic           cancel_o
);
    import mwu_pkg::*;

    act_e state_q;
    act_e state_d;
    logic cancel_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ACT_RUN;
            cancel_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cancel_q <= hit;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACT_RUN: begin
                if (wait_go && !hit && !irq_unmasked)
                    state_d = wait_hint ? ACT_WAIT_IRQ : ACT_WAIT;
            end
            ACT_WAIT: begin
                if (hit || irq_unmasked)
                    state_d = ACT_RUN;
            end
            ACT_WAIT_IRQ: begin
                if (hit || irq_unmasked || irq_break)
                    state_d = ACT_RUN;
            end
            default: state_d = ACT_RUN;
        endcase
    end

    // Outputs.
    always_comb begin
        state_o  = state_q;
        running  = (state_q == ACT_RUN);
        cancel_o = cancel_q;
    end

endmodule

// File: rtl/mon_wake_unit.sv
module mon_wake_unit #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LEN_W      = 8,
    parameter int unsigned LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_valid,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic [1:0]        arm_src,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic [LEN_W-1:0]  snoop_len,
    input  logic              mon_clear,
    input  logic              wait_valid,
    input  logic              wait_family,
    input  logic              wait_monless,
    input  logic              wait_hint_irq,
    input  logic              irq_unmasked,
    input  logic              irq_break,
    output logic              armed,
    output logic [1:0]        armed_src,
    output logic [1:0]        act_state,
    output logic              timer_cancel
);
    import mwu_pkg::*;

    logic              arm_load;
    logic              arm_drop;
    logic              armed_q;
    logic [ADDR_W-1:0] base_q;
    src_e              src_q;
    logic              snoop_hit;
    logic              wait_go;
    logic              monless_req;
    logic              running;
    act_e              state;
    logic              cancel;

    assign arm_load = arm_valid && (src_e'(arm_src) != SRC_NONE);
    assign arm_drop = mon_clear || snoop_hit || (monless_req && running);

    mwu_arm_reg #(.ADDR_W(ADDR_W)) u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (arm_load),
        .load_addr (arm_addr),
        .load_src  (src_e'(arm_src)),
        .drop      (arm_drop),
        .armed_q   (armed_q),
        .base_q    (base_q),
        .src_q     (src_q)
    );

    mwu_line_match #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_match (
        .armed    (armed_q),
        .base     (base_q),
        .wr_valid (snoop_valid),
        .wr_addr  (snoop_addr),
        .wr_len   (snoop_len),
        .hit      (snoop_hit)
    );

    mwu_wait_gate u_gate (
        .wait_valid   (wait_valid),
        .wait_family  (wait_family),
        .wait_monless (wait_monless),
        .armed        (armed_q),
        .src          (src_q),
        .go           (wait_go),
        .monless_req  (monless_req)
    );

    mwu_act_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit          (snoop_hit),
        .irq_unmasked (irq_unmasked),
        .irq_break    (irq_break),
        .wait_go      (wait_go),
        .wait_hint    (wait_hint_irq),
        .state_o      (state),
        .running      (running),
        .cancel_o     (cancel)
    );

    assign armed        = armed_q;
    assign armed_src    = src_q;
    assign act_state    = state;
    assign timer_cancel = cancel;

endmodule

// File: rtl/mwu_checks.sv
module mwu_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       arm_valid,
    input logic [1:0] arm_src,
    input logic       snoop_valid,
    input logic       mon_clear,
    input logic       wait_valid,
    input logic       wait_family,
    input logic       wait_monless,
    input logic       irq_unmasked,
    input logic       snoop_hit,
    input logic       armed,
    input logic [1:0] armed_src,
    input logic [1:0] act_state,
    input logic       timer_cancel
);
    logic arm_now;
    assign arm_now = arm_valid && (arm_src != 2'd0);

    AST_IDLE_TAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> armed_src == 2'd0);                                           // R4
    AST_HIT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_hit && !arm_now) |=> !armed);                                     // R4
    AST_HIT_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_hit |=> act_state == 2'd0);                                        // R5
    AST_NO_SNOOP_NO_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        !snoop_valid |=> !timer_cancel);                                         // R6
    AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !timer_cancel);                                               // R7
    AST_CLEAR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_clear && !arm_now) |=> !armed);                                     // R8
    AST_WRONG_TAG_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (act_state == 2'd0 && wait_valid && !wait_monless &&
         armed_src != (wait_family ? 2'd2 : 2'd1)) |=> act_state == 2'd0);       // R9
    AST_MONLESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (act_state == 2'd0 && wait_valid && wait_monless && !arm_now) |=> !armed); // R10
    AST_UNMASKED_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_state != 2'd0 && irq_unmasked) |=> act_state == 2'd0);              // R12
    AST_BREAK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (act_state == 2'd1 && !irq_unmasked && !snoop_hit) |=> act_state == 2'd1); // R12
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        act_state != 2'd3);                                                      // R11

endmodule

bind mon_wake_unit mwu_checks u_mwu_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm_valid    (arm_valid),
    .arm_src      (arm_src),
    .snoop_valid  (snoop_valid),
    .mon_clear    (mon_clear),
    .wait_valid   (wait_valid),
    .wait_family  (wait_family),
    .wait_monless (wait_monless),
    .irq_unmasked (irq_unmasked),
    .snoop_hit    (snoop_hit),
    .armed        (armed),
    .armed_src    (armed_src),
    .act_state    (act_state),
    .timer_cancel (timer_cancel)
);

// File: tb/mon_wake_unit_tb.sv
module mon_wake_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 31;

    typedef struct packed {
        logic        arm_v;
        logic [31:0] arm_a;
        logic [1:0]  arm_s;
        logic        snp_v;
        logic [31:0] snp_a;
        logic [7:0]  snp_l;
        logic        clr;
        logic        wt_v;
        logic        wt_f;
        logic        wt_ml;
        logic        wt_h;
        logic        irq_u;
        logic        irq_b;
        logic [5:0]  exp;   // {armed, armed_src, act_state, timer_cancel}
        logic [3:0]  req;
    } vec_t;

    // arm_v arm_a arm_s | snp_v snp_a snp_l | clr wt_v wt_f wt_ml wt_h irq_u irq_b | exp | req
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 32'h1000, 2'd1, 1'b0, 32'h0,    8'd0,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b1_01_00_0, 4'd2},  // R2 arm privileged
        '{1'b0, 32'h0,    2'd0, 1'b1, 32'h0FF0, 8'd16,  1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b1_01_00_0, 4'd3},  // R3 ends at base
        '{1'b0, 32'h0,    2'd0, 1'b1, 32'h103F, 8'd1,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b1_01_00_0, 4'd3},  // R3 exclusive last byte
        '{1'b0, 32'h0,    2'd0, 1'b0, 32'h0,    8'd0,   1'b0, 1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0, 6'b1_01_00_0, 4'd9},  // R9 ext wait, priv tag
        '{1'b0, 32'h0,    2'd0, 1'b0, 32'h0,    8'd0,   1'b0, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b1_01_01_0, 4'd11}, // R11 plain wait
        '{1'b0, 32'h0,    2'd0, 1'b0, 32'h0,    8'd0,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1, 6'b1_01_01_0, 4'd12}, // R12 break ignored
        '{1'b0, 32'h0,    2'd0, 1'b0, 32'h0,    8'd0,   1'b0, 1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 6'b1_01_01_0, 4'd13}, // R13 wait in wait
        '{1'b0, 32'h0,    2'd0, 1'b1, 32'h103E, 8'd1,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b0_00_00_1, 4'd5},  // R4 R5 hit wakes
        '{1'b0, 32'h0,    2'd0, 1'b0, 32'h0,    8'd0,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b0_00_00_0, 4'd6},  // R6 pulse ends
        '{1'b0, 32'h0,    2'd0, 1'b1, 32'h1000, 8'd4,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b0_00_00_0, 4'd7},  // R7 unarmed snoop
        '{1'b1, 32'h2000, 2'd2, 1'b0, 32'h0,    8'd0,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b1_10_00_0, 4'd2},  // R2 arm extended
        '{1'b0, 32'h0,    2'd0, 1'b0, 32'h0,    8'd0,   1'b0, 1'b1,1'b1,1'b0,1'b1, 1'b0,1'b0, 6'b1_10_10_0, 4'd11}, // R11 hinted wait
        '{1'b0, 32'h0,    2'd0, 1'b0, 32'h0,    8'd0,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1, 6'b1_10_00_0, 4'd12}, // R12 break wakes
        '{1'b0, 32'h0,    2'd0, 1'b0, 32'h0,    8'd0,   1'b0, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b1_10_00_0, 4'd9},  // R9 priv wait, ext tag
        '{1'b1, 32'h3000, 2'd3, 1'b0, 32'h0,    8'd0,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b1_11_00_0, 4'd2},  // R2 arm user
        '{1'b0, 32'h0,    2'd0, 1'b0, 32'h0,    8'd0,   1'b0, 1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0, 6'b0_00_01_0, 4'd10}, // R10 monitorless
        '{1'b0, 32'h0,    2'd0, 1'b0, 32'h0,    8'd0,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 6'b0_00_00_0, 4'd12}, // R12 unmasked wakes
        '{1'b1, 32'h4000, 2'd1, 1'b0, 32'h0,    8'd0,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b1_01_00_0, 4'd2},
        '{1'b1, 32'h5000, 2'd2, 1'b0, 32'h0,    8'd0,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b1_10_00_0, 4'd2},  // R2 overwrite
        '{1'b0, 32'h0,    2'd0, 1'b1, 32'h4000, 8'd8,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b1_10_00_0, 4'd3},  // R3 old window
        '{1'b0, 32'h0,    2'd0, 1'b1, 32'h4FF8, 8'd16,  1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b0_00_00_1, 4'd3},  // R3 straddles base
        '{1'b1, 32'h6000, 2'd1, 1'b0, 32'h0,    8'd0,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b1_01_00_0, 4'd2},
        '{1'b0, 32'h0,    2'd0, 1'b0, 32'h0,    8'd0,   1'b1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b0_00_00_0, 4'd8},  // R8 clear
        '{1'b1, 32'h6000, 2'd1, 1'b0, 32'h0,    8'd0,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b1_01_00_0, 4'd2},
        '{1'b0, 32'h0,    2'd0, 1'b0, 32'h0,    8'd0,   1'b0, 1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 6'b1_01_10_0, 4'd11},
        '{1'b0, 32'h0,    2'd0, 1'b0, 32'h0,    8'd0,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 6'b1_01_00_0, 4'd12}, // R12
        '{1'b1, 32'h7000, 2'd0, 1'b0, 32'h0,    8'd0,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b1_01_00_0, 4'd2},  // R2 tag 0 ignored
        '{1'b0, 32'h0,    2'd0, 1'b1, 32'h6000, 8'd1,   1'b0, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b0_00_00_1, 4'd9},  // R9 hit blocks wait
        '{1'b1, 32'h6000, 2'd1, 1'b0, 32'h0,    8'd0,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b1_01_00_0, 4'd2},
        '{1'b1, 32'h8000, 2'd2, 1'b1, 32'h6010, 8'd1,   1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b1_10_00_1, 4'd2},  // R2 arm beats hit
        '{1'b0, 32'h0,    2'd0, 1'b1, 32'h7FF0, 8'h80,  1'b0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 6'b0_00_00_1, 4'd3}   // R3 covers line
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        arm_valid, snoop_valid, mon_clear;
    logic [31:0] arm_addr, snoop_addr;
    logic [1:0]  arm_src;
    logic [7:0]  snoop_len;
    logic        wait_valid, wait_family, wait_monless, wait_hint_irq;
    logic        irq_unmasked, irq_break;
    logic        armed, timer_cancel;
    logic [1:0]  armed_src, act_state;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mon_wake_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .arm_valid(arm_valid), .arm_addr(arm_addr), .arm_src(arm_src),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_len(snoop_len),
        .mon_clear(mon_clear),
        .wait_valid(wait_valid), .wait_family(wait_family),
        .wait_monless(wait_monless), .wait_hint_irq(wait_hint_irq),
        .irq_unmasked(irq_unmasked), .irq_break(irq_break),
        .armed(armed), .armed_src(armed_src), .act_state(act_state),
        .timer_cancel(timer_cancel)
    );

    task automatic drive(input vec_t v);
        arm_valid     = v.arm_v;  arm_addr   = v.arm_a;  arm_src   = v.arm_s;
        snoop_valid   = v.snp_v;  snoop_addr = v.snp_a;  snoop_len = v.snp_l;
        mon_clear     = v.clr;
        wait_valid    = v.wt_v;   wait_family = v.wt_f;
        wait_monless  = v.wt_ml;  wait_hint_irq = v.wt_h;
        irq_unmasked  = v.irq_u;  irq_break  = v.irq_b;
    endtask

    task automatic check(input string tag, input logic [5:0] exp);
        logic [5:0] act;
        act = {armed, armed_src, act_state, timer_cancel};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {armed,src,state,cancel} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input vec_t v, input string tag);
        @(negedge clk);
        drive(v);
        @(posedge clk);
        #1;
        check(tag, v.exp);
    endtask

    function automatic vec_t idle();
        vec_t v;
        v = '0;
        return v;
    endfunction

    function automatic vec_t mk(input logic av, input logic [31:0] aa, input logic [1:0] as,
                                input logic sv, input logic [31:0] sa, input logic [7:0] sl,
                                input logic wv, input logic wh, input logic iu,
                                input logic [5:0] e);
        vec_t v;
        v = '0;
        v.arm_v = av; v.arm_a = aa; v.arm_s = as;
        v.snp_v = sv; v.snp_a = sa; v.snp_l = sl;
        v.wt_v = wv; v.wt_h = wh; v.irq_u = iu; v.exp = e;
        return v;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        drive(idle());
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", 6'b0_00_00_0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i], $sformatf("vector %0d R%0d", i, VEC[i].req));
        end

        // R3: window near the top of the address space must not wrap.
        step(mk(1'b1, 32'hFFFF_FFF0, 2'd1, 1'b0, 32'h0, 8'd0, 1'b0, 1'b0, 1'b0,
                6'b1_01_00_0), "R3 arm high window");
        step(mk(1'b0, 32'h0, 2'd0, 1'b1, 32'hFFFF_FFF8, 8'd16, 1'b0, 1'b0, 1'b0,
                6'b0_00_00_1), "R3 high window hit");

        // R3: write ending one byte past base is a hit.
        step(mk(1'b1, 32'h9000, 2'd1, 1'b0, 32'h0, 8'd0, 1'b0, 1'b0, 1'b0,
                6'b1_01_00_0), "R3 arm");
        step(mk(1'b0, 32'h0, 2'd0, 1'b1, 32'h8FFF, 8'd2, 1'b0, 1'b0, 1'b0,
                6'b0_00_00_1), "R3 one byte inside base");

        // R1: reset in the middle of a wait.
        step(mk(1'b1, 32'hA000, 2'd1, 1'b0, 32'h0, 8'd0, 1'b0, 1'b0, 1'b0,
                6'b1_01_00_0), "R1 arm before reset");
        step(mk(1'b0, 32'h0, 2'd0, 1'b0, 32'h0, 8'd0, 1'b1, 1'b1, 1'b0,
                6'b1_01_10_0), "R1 wait before reset");
        @(negedge clk);
        drive(idle());
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset during wait", 6'b0_00_00_0);
        @(negedge clk);
        rst_n = 1'b1;
        step(idle(), "R1 idle after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule